// File: doc/BRIEF.md
# Byte-serial packet mailbox

This peripheral carries whole packets between a host register port and a pair of byte streams. On the host side every transfer moves one byte per register access: the host reads received bytes out of a data window, and it writes outbound bytes into another window after announcing the packet length. On the device side an inbound stream fills an internal receive store, and an outbound stream drains the transmit store one byte per handshake.

A single level interrupt tells the host that a packet has arrived or that an outbound packet has been consumed. The interrupt register also holds a self-test source. The host can raise that source to prove the interrupt path works, and it clears the source with a read followed by a write of zero.

Top module: `pktbox`

## Requirements
- R1: Offsets 0x00 (bits 31:0) and 0x04 (bits 63:32) together read a 64-bit identifier of eight ASCII characters "PKTMBOX" followed by the digit '0'+VERSION. The first character sits in bits 7:0 of offset 0x00.
- R2: Bit 0 of offset 0x08 reads 1 while an inbound packet is partly received or an outbound packet is being loaded or emitted, and 0 otherwise. After reset, every register except the identifier and offset 0x18 reads 0, and irq is low.
- R3: Once an inbound byte flagged with in_last is accepted, offset 0x0C reads the packet length and bit 1 of offset 0x14 (receive done) is set.
- R4: Each read of offset 0x1C, while the receive count is nonzero, returns the next received byte in arrival order in bits 7:0, with bits 31:8 zero, and lowers the receive count by one.
- R5: A read of offset 0x1C while the receive count is 0 returns 0 and leaves the count at 0.
- R6: in_ready is low while the receive count is nonzero, and no inbound byte is taken until the host has drained the packet. Packets may be up to BUF_DEPTH bytes long.
- R7: Writing a length from 1 to BUF_DEPTH to offset 0x10 while no outbound packet is in flight arms a transmit. Offset 0x10 then reads that length. The low byte of each of the next that-many writes to offset 0x20 is emitted on out_data in order, with out_last on the final byte. out_valid and out_data hold until out_ready. A length of 0 or above BUF_DEPTH is ignored.
- R8: After the final outbound byte is taken, offset 0x10 reads 0 and bit 0 of offset 0x14 (transmit done) is set. Writes to offset 0x20 while no length is armed are ignored.
- R9: Writing 1 to bit 0 or bit 1 of offset 0x14 clears that bit. Writing 0 to either bit leaves it unchanged.
- R10: Any write to offset 0x14 with bit 31 set raises the test bit (bit 31). Only a write of all zeros clears it, and only when that write follows a read of offset 0x14 that saw the bit set. A zero write without that read leaves the bit set.
- R11: irq is high exactly when any of bits 0, 1 or 31 of offset 0x14 is set.
- R12: Offset 0x18 reads the IRQ_INFO parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_rd | input | 1 | Host read strobe; side effects occur at the clock edge |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 6 | Byte offset within the 0x40 window |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid in the cycle of hst_rd |
| irq | output | 1 | Level interrupt |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound byte |
| in_last | input | 1 | Inbound byte ends the packet |
| in_ready | output | 1 | Inbound byte accepted when high with in_valid |
| out_valid | output | 1 | Outbound byte valid |
| out_data | output | 8 | Outbound byte |
| out_last | output | 1 | Outbound byte ends the packet |
| out_ready | input | 1 | Outbound byte taken when high with out_valid |

## Verification
The checker takes for granted that the host never reads and writes in the same cycle. It also assumes inbound packets never exceed BUF_DEPTH bytes, because a longer packet would stall at a full store. The bench drives one strobe per access with an idle cycle between accesses, and its length sweeps stop at BUF_DEPTH. The outbound consumer alternates between a steady ready and a pattern that stalls one cycle in three, so the hold property sees real back-pressure.

// File: rtl/pktbox_pkg.sv
package pktbox_pkg;
   // Byte offsets within the 0x40 register window
   localparam logic [5:0] A_IDLO   = 6'h00;
   localparam logic [5:0] A_IDHI   = 6'h04;
   localparam logic [5:0] A_BUSY   = 6'h08;
   localparam logic [5:0] A_RXCNT  = 6'h0C;
   localparam logic [5:0] A_TXCNT  = 6'h10;
   localparam logic [5:0] A_INTCTL = 6'h14;
   localparam logic [5:0] A_INFO   = 6'h18;
   localparam logic [5:0] A_RXDAT  = 6'h1C;
   localparam logic [5:0] A_TXDAT  = 6'h20;

   typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SEND} tx_state_t;
endpackage

// File: rtl/pktbox_rx.sv
module pktbox_rx #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic             pop,
   output logic             in_ready,
   output logic [CNT_W-1:0] count,
   output logic [7:0]       byte_out,
   output logic             active,
   output logic             done
);
   localparam int PW = $clog2(DEPTH + 1);
   localparam int IW = $clog2(DEPTH);

   logic [7:0]    mem [0:DEPTH-1];
   logic [PW-1:0] wptr;
   logic [IW-1:0] rptr;
   logic          accept, take;

   // new packets only enter an empty store
   assign in_ready = (count == '0) && (wptr < PW'(DEPTH));
   assign accept   = in_valid && in_ready;
   assign take     = pop && (count != '0);
   assign done     = accept && in_last;
   assign active   = (wptr != '0);
   assign byte_out = (count != '0) ? mem[rptr] : 8'h00;

   always_ff @(posedge clk) begin
      if (accept) mem[wptr[IW-1:0]] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (accept) begin
         if (in_last) begin
            count <= CNT_W'(wptr) + CNT_W'(1);
            wptr  <= '0;
            rptr  <= '0;
         end else begin
            wptr <= wptr + PW'(1);
         end
      end else if (take) begin
         rptr  <= rptr + IW'(1);
         count <= count - CNT_W'(1);
      end
   end
endmodule

// File: rtl/pktbox_tx.sv
module pktbox_tx
   import pktbox_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_wr,
   input  logic [CNT_W-1:0] len_val,
   input  logic             byte_wr,
   input  logic [7:0]       byte_val,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_last,
   output logic [CNT_W-1:0] count,
   output logic             active,
   output logic             done
);
   localparam int IW = $clog2(DEPTH);

   tx_state_t        state;
   logic [7:0]       mem [0:DEPTH-1];
   logic [CNT_W-1:0] ptr;
   logic             len_ok, at_end;

   assign len_ok    = (len_val != '0) && (len_val <= CNT_W'(DEPTH));
   assign at_end    = (ptr + CNT_W'(1)) == count;
   assign out_valid = (state == TX_SEND);
   assign out_data  = mem[ptr[IW-1:0]];
   assign out_last  = out_valid && at_end;
   assign done      = out_valid && out_ready && at_end;
   assign active    = (state != TX_IDLE);

   always_ff @(posedge clk) begin
      if (state == TX_LOAD && byte_wr) mem[ptr[IW-1:0]] <= byte_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         count <= '0;
         ptr   <= '0;
      end else begin
         case (state)
            TX_IDLE: if (len_wr && len_ok) begin
               count <= len_val;
               ptr   <= '0;
               state <= TX_LOAD;
            end
            TX_LOAD: if (byte_wr) begin
               if (at_end) begin
                  ptr   <= '0;
                  state <= TX_SEND;
               end else begin
                  ptr <= ptr + CNT_W'(1);
               end
            end
            TX_SEND: if (out_ready) begin
               if (at_end) begin
                  count <= '0;
                  ptr   <= '0;
                  state <= TX_IDLE;
               end else begin
                  ptr <= ptr + CNT_W'(1);
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pktbox_irq.sv
module pktbox_irq (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tx_set,
   input  logic        rx_set,
   input  logic        wr,
   input  logic [31:0] wdata,
   input  logic        rd,
   output logic [31:0] status,
   output logic        irq
);
   logic f_tx, f_rx, f_tst, armed;

   assign status = {f_tst, 29'b0, f_rx, f_tx};
   assign irq    = f_tx | f_rx | f_tst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_tx  <= 1'b0;
         f_rx  <= 1'b0;
         f_tst <= 1'b0;
         armed <= 1'b0;
      end else begin
         f_tx <= tx_set | (f_tx & ~(wr & wdata[0]));
         f_rx <= rx_set | (f_rx & ~(wr & wdata[1]));
         if (wr && wdata[31]) begin
            f_tst <= 1'b1;
            armed <= 1'b0;
         end else if (wr && wdata == 32'h0 && armed) begin
            f_tst <= 1'b0;
            armed <= 1'b0;
         end else if (rd && f_tst) begin
            armed <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pktbox.sv
module pktbox
   import pktbox_pkg::*;
#(
   parameter int          BUF_DEPTH = 16,
   parameter int          CNT_W     = 17,
   parameter int          VERSION   = 1,
   parameter logic [31:0] IRQ_INFO  = 32'd2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hst_rd,
   input  logic        hst_wr,
   input  logic [5:0]  hst_addr,
   input  logic [31:0] hst_wdata,
   output logic [31:0] hst_rdata,
   output logic        irq,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   input  logic        in_last,
   output logic        in_ready,
   output logic        out_valid,
   output logic [7:0]  out_data,
   output logic        out_last,
   input  logic        out_ready
);
   localparam logic [63:0] DEV_ID =
      {8'(8'h30 + VERSION), "X", "O", "B", "M", "T", "K", "P"};

   if (BUF_DEPTH < 2 || BUF_DEPTH > 65536 || CNT_W < 17 || CNT_W > 32 ||
       VERSION < 0 || VERSION > 9) begin : g_param_err
      $error("pktbox: parameter out of range");
   end

   logic [CNT_W-1:0] rx_count, tx_count;
   logic [7:0]       rx_byte;
   logic             rx_active, tx_active, rx_done, tx_done, busy;
   logic [31:0]      irq_status;

   assign busy = rx_active | tx_active;

   pktbox_rx #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .pop(hst_rd && hst_addr == A_RXDAT),
      .in_ready(in_ready), .count(rx_count), .byte_out(rx_byte),
      .active(rx_active), .done(rx_done)
   );

   pktbox_tx #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .len_wr(hst_wr && hst_addr == A_TXCNT), .len_val(hst_wdata[CNT_W-1:0]),
      .byte_wr(hst_wr && hst_addr == A_TXDAT), .byte_val(hst_wdata[7:0]),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .count(tx_count), .active(tx_active), .done(tx_done)
   );

   pktbox_irq u_irq (
      .clk(clk), .rst_n(rst_n),
      .tx_set(tx_done), .rx_set(rx_done),
      .wr(hst_wr && hst_addr == A_INTCTL), .wdata(hst_wdata),
      .rd(hst_rd && hst_addr == A_INTCTL),
      .status(irq_status), .irq(irq)
   );

   always_comb begin
      case (hst_addr)
         A_IDLO:   hst_rdata = DEV_ID[31:0];
         A_IDHI:   hst_rdata = DEV_ID[63:32];
         A_BUSY:   hst_rdata = {31'b0, busy};
         A_RXCNT:  hst_rdata = 32'(rx_count);
         A_TXCNT:  hst_rdata = 32'(tx_count);
         A_INTCTL: hst_rdata = irq_status;
         A_INFO:   hst_rdata = IRQ_INFO;
         A_RXDAT:  hst_rdata = {24'b0, rx_byte};
         default:  hst_rdata = 32'h0;
      endcase
   end
endmodule

// File: rtl/pktbox_chk.sv
module pktbox_chk
   import pktbox_pkg::*;
#(
   parameter int CNT_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hst_rd,
   input logic [5:0]       hst_addr,
   input logic [CNT_W-1:0] rx_count,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_data,
   input logic             out_last,
   input logic             busy,
   input logic             flag_tx
);
   // R4
   rx_pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && hst_addr == A_RXDAT && rx_count != '0) |=>
      rx_count == $past(rx_count) - CNT_W'(1));

   // R5
   rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && hst_addr == A_RXDAT && rx_count == '0 && !(in_valid && in_ready)) |=>
      rx_count == '0);

   // R6
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count != '0 && !(hst_rd && hst_addr == A_RXDAT)) |=>
      rx_count == $past(rx_count));

   // R6
   rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count != '0) |-> !in_ready);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
      out_valid && $stable(out_data) && $stable(out_last));

   // R2
   send_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

   // R8
   txdone_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_tx) |-> $past(out_valid && out_ready && out_last));
endmodule

bind pktbox pktbox_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_addr(hst_addr),
   .rx_count(rx_count), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_last(out_last), .busy(busy), .flag_tx(irq_status[0])
);

// File: tb/pktbox_test.sv
module pktbox_test;
   localparam int          DEPTH = 16;
   localparam int          VER   = 1;
   localparam logic [31:0] INFO  = 32'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_rd = 1'b0, hst_wr = 1'b0;
   logic [5:0]  hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic        irq;
   logic        in_valid = 1'b0, in_last = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic        out_valid, out_last;
   logic [7:0]  out_data;
   logic        out_ready = 1'b1;

   int n_run = 0, n_fail = 0;
   logic [7:0] cap [0:63];
   logic       cap_last [0:63];
   int         ncap = 0;
   int         stall = 0;
   int         cyc = 0;

   always #10 clk = ~clk;

   pktbox #(.BUF_DEPTH(DEPTH), .VERSION(VER), .IRQ_INFO(INFO)) uut (
      .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .irq(irq), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .out_ready(out_ready)
   );

   // outbound collector; ready pattern changes only at the falling edge
   always @(negedge clk) begin
      if (out_valid && out_ready && ncap < 64) begin
         cap[ncap]      = out_data;
         cap_last[ncap] = out_last;
         ncap++;
      end
      cyc++;
      out_ready = (stall != 0) ? ((cyc % 3) != 0) : 1'b1;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      hst_rd = 1'b1; hst_addr = a;
      #2 d = hst_rdata;
      @(negedge clk);
      hst_rd = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int l, input int i);
      return 8'((l * 37 + i * 11 + 5) & 255);
   endfunction

   task automatic send_pkt(input int len, input int seed, input bit fin);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = pat(seed, i);
         in_last = fin && (i == len - 1);
         while (!in_ready) @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [63:0] id_exp;
      string s;
      s = "PKTMBOX";
      for (int i = 0; i < 7; i++) id_exp[i*8 +: 8] = s[i];
      id_exp[63:56] = 8'(8'h30 + VER);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      bus_rd(6'h00, d); check("R1 id low", d, id_exp[31:0]);
      bus_rd(6'h04, d); check("R1 id high", d, id_exp[63:32]);
      bus_rd(6'h08, d); check("R2 busy reset", d, 0);
      bus_rd(6'h0C, d); check("R2 rx count reset", d, 0);
      bus_rd(6'h10, d); check("R2 tx count reset", d, 0);
      bus_rd(6'h14, d); check("R2 intctl reset", d, 0);
      check("R11 irq reset", irq, 0);
      bus_rd(6'h18, d); check("R12 info", d, INFO);

      // receive sweep over every length
      for (int len = 1; len <= DEPTH; len++) begin
         send_pkt(len, len, 1'b1);
         bus_rd(6'h0C, d); check("R3 rx count", d, len);
         bus_rd(6'h14, d); check("R3 rx done", d, 32'h2);
         check("R11 irq rx", irq, 1);
         check("R6 in_ready low", in_ready, 0);
         if (len == 5) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'hAA; in_last = 1'b1;
            repeat (3) @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            bus_rd(6'h0C, d); check("R6 no new packet", d, 5);
         end
         for (int i = 0; i < len; i++) begin
            bus_rd(6'h1C, d); check("R4 rx byte", d, {24'b0, pat(len, i)});
            bus_rd(6'h0C, d); check("R4 rx count dec", d, len - 1 - i);
         end
         bus_rd(6'h1C, d); check("R5 empty read", d, 0);
         bus_rd(6'h0C, d); check("R5 count stays", d, 0);
         if (len == 1) begin
            bus_wr(6'h14, 32'h1);
            bus_rd(6'h14, d); check("R9 other bit kept", d, 32'h2);
            bus_wr(6'h14, 32'h0);
            bus_rd(6'h14, d); check("R9 zero write kept", d, 32'h2);
         end
         bus_wr(6'h14, 32'h2);
         bus_rd(6'h14, d); check("R9 rx clear", d, 0);
         check("R11 irq cleared", irq, 0);
      end

      // busy during partial inbound packet
      send_pkt(3, 3, 1'b0);
      bus_rd(6'h08, d); check("R2 busy rx fill", d, 1);
      send_pkt(2, 2, 1'b1);
      bus_rd(6'h08, d); check("R2 busy rx done", d, 0);
      bus_rd(6'h0C, d); check("R3 joined count", d, 5);
      bus_rd(6'h1C, d); check("R4 joined first", d, {24'b0, pat(3, 0)});
      for (int i = 0; i < 4; i++) bus_rd(6'h1C, d);
      bus_rd(6'h0C, d); check("R4 joined drained", d, 0);
      bus_wr(6'h14, 32'h2);

      // transmit sweep, stalling consumer on odd lengths
      for (int len = 1; len <= DEPTH; len++) begin
         int guard;
         stall = len % 2;
         ncap = 0;
         bus_wr(6'h10, len);
         bus_rd(6'h10, d); check("R7 tx count", d, len);
         bus_rd(6'h08, d); check("R2 busy tx", d, 1);
         for (int i = 0; i < len; i++)
            bus_wr(6'h20, {24'hA5C3_F0, pat(len + 40, i)});
         guard = 0;
         while (ncap < len && guard < 500) begin @(negedge clk); guard++; end
         check("R7 tx byte count", ncap, len);
         for (int i = 0; i < len; i++) begin
            check("R7 tx byte", cap[i], pat(len + 40, i));
            check("R7 tx last", cap_last[i], (i == len - 1));
         end
         @(negedge clk);
         bus_rd(6'h10, d); check("R8 tx count cleared", d, 0);
         bus_rd(6'h08, d); check("R2 busy tx end", d, 0);
         bus_rd(6'h14, d); check("R8 tx done", d, 32'h1);
         check("R11 irq tx", irq, 1);
         bus_wr(6'h14, 32'h1);
         bus_rd(6'h14, d); check("R9 tx clear", d, 0);
      end
      stall = 0;

      // ignored writes: data with no length, bad lengths
      ncap = 0;
      bus_wr(6'h20, 32'h77);
      bus_wr(6'h10, 0);
      bus_rd(6'h10, d); check("R7 zero length ignored", d, 0);
      bus_wr(6'h10, DEPTH + 1);
      bus_rd(6'h10, d); check("R7 long length ignored", d, 0);
      bus_wr(6'h10, 2);
      bus_wr(6'h20, 32'h10);
      bus_wr(6'h20, 32'h11);
      repeat (6) @(negedge clk);
      check("R8 stray data count", ncap, 2);
      check("R8 stray data first", cap[0], 8'h10);
      check("R8 stray data second", cap[1], 8'h11);
      bus_wr(6'h14, 32'h1);

      // self-test source
      bus_wr(6'h14, 32'h8000_0000);
      check("R11 irq test", irq, 1);
      bus_wr(6'h14, 32'h0);
      check("R10 zero without read", irq, 1);
      bus_rd(6'h14, d); check("R10 test bit read", d, 32'h8000_0000);
      check("R10 read alone keeps", irq, 1);
      bus_wr(6'h14, 32'h0);
      bus_rd(6'h14, d); check("R10 test cleared", d, 0);
      check("R11 irq test cleared", irq, 0);

      summary();
      $finish;
   end
endmodule